// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block carries out a single read or write transfer on an external bus where the address and the data share one set of wires at different times. A core asserts a request together with an address, write data, a direction bit and an optional stretch flag. The block latches these values and then steps the bus through a fixed series of phases:

- It drives the address while pulsing an active-low address strobe.
- It removes the address from the shared wires.
- It pulses an active-low data strobe, during which write data is driven or read data is returned by the external device.
- It signals completion to the core with a one-cycle done pulse.

A read/write line tells the external device the direction for the whole transfer. All timing is counted in system clock periods. With the stretch flag set, the data strobe stays low for two extra periods to suit slower devices. Only one transfer runs at a time. Requests seen while a transfer is in progress are ignored and are not queued.

Top module: `xbus_seq`

## Requirements
- R1: Out of reset and between transfers, the address strobe, the data strobe and the read/write line are high, the bus output enable is low, and done is low.
- R2: A request sampled high while idle starts a transfer. The address strobe is low for exactly the next cycle, with the bus enabled and carrying the address captured when the request was accepted. Later changes on the core inputs do not affect the running transfer.
- R3: In the cycle after the address strobe rises, the same address is still driven on the bus.
- R4: On a read, the bus output enable is low in the cycle before the data strobe falls and in every cycle while the data strobe is low.
- R5: The read/write line is high for a read and low for a write, from the address-strobe-low cycle through the cycle after the data strobe rises. It is high in all other cycles.
- R6: On a write, the write data is driven with the output enable high from the cycle before the data strobe falls through the cycle after it rises.
- R7: The data strobe is low for one cycle normally, and for three cycles when the stretch flag was set at acceptance.
- R8: On a read, the read data output takes the value present on the bus input during the last data-strobe-low cycle, and is held until the next read completes. A write leaves it unchanged.
- R9: Done is a single-cycle pulse. It occurs 6 cycles after the accepting clock edge for a normal transfer and 8 cycles after it for a stretched transfer, where the first cycle after the accepting edge counts as 1.
- R10: Requests held high while a transfer is running are ignored. No new address strobe falls before the cycle after done.
- R11: The address strobe and the data strobe are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a transfer (sampled while idle) |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| ext_i | input | 1 | Stretch the data strobe by two periods |
| addr_i | input | W | Transfer address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| ad_o | output | W | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | W | Shared bus input value |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_n_o | output | 1 | Read/write line: high read, low write |

## Verification
The assertions assume that a synchronous reset release occurs and that the external device only presents data on the bus input. They place no constraint on when the core raises a request. The stimulus exercises this freedom: requests are held high across running transfers, and the core inputs are changed right after acceptance. The stimulus also drives a decoy value on the bus input in every data-strobe-low cycle except the last, so that a capture at the wrong edge shows up as a wrong read value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_ASHI  = 3'd2,
        PH_FLOAT = 3'd3,
        PH_DSLO  = 3'd4,
        PH_DSHI  = 3'd5,
        PH_DONE  = 3'd6
    } phase_e;

endpackage

// File: rtl/xbus_stretch.sv
module xbus_stretch #(
    parameter int EXTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic ext,
    input  logic run,
    output logic last
);
    localparam int CW = (EXTRA < 1) ? 1 : $clog2(EXTRA + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = ext ? CW'(EXTRA) : '0;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int W = 8
) (
    input  phase_e         phase,
    input  logic [W-1:0]   addr,
    input  logic [W-1:0]   wdata,
    input  logic           rd,
    output logic [W-1:0]   ad_o,
    output logic           ad_oe,
    output logic           as_n,
    output logic           ds_n,
    output logic           rw_n,
    output logic           done
);
    logic addr_ph, data_ph, dir_ph;

    always_comb begin
        addr_ph = (phase == PH_ADDR) || (phase == PH_ASHI);
        data_ph = !rd && ((phase == PH_FLOAT) || (phase == PH_DSLO) || (phase == PH_DSHI));
        dir_ph  = (phase != PH_IDLE) && (phase != PH_DONE);
        as_n    = (phase != PH_ADDR);
        ds_n    = (phase != PH_DSLO);
        rw_n    = dir_ph ? rd : 1'b1;
        done    = (phase == PH_DONE);
        ad_oe   = addr_ph || data_ph;
        if (addr_ph)      ad_o = addr;
        else if (data_ph) ad_o = wdata;
        else              ad_o = '0;
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int W     = 8,
    parameter int EXTRA = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_i,
    input  logic         rd_i,
    input  logic         ext_i,
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         done_o,
    output logic [W-1:0] ad_o,
    output logic         ad_oe_o,
    input  logic [W-1:0] ad_i,
    output logic         as_n_o,
    output logic         ds_n_o,
    output logic         rw_n_o
);
    typedef struct packed {
        phase_e       phase;
        logic [W-1:0] addr;
        logic [W-1:0] wdata;
        logic         rd;
        logic         ext;
        logic [W-1:0] rdata;
    } seq_t;

    seq_t r_d, r_q;
    logic load, ds_last;

    xbus_stretch #(.EXTRA(EXTRA)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .ext   (r_q.ext),
        .run   (r_q.phase == PH_DSLO),
        .last  (ds_last)
    );

    always_comb begin
        r_d  = r_q;
        load = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: if (req_i) begin
                r_d.phase = PH_ADDR;
                r_d.addr  = addr_i;
                r_d.wdata = wdata_i;
                r_d.rd    = rd_i;
                r_d.ext   = ext_i;
            end
            PH_ADDR:  r_d.phase = PH_ASHI;
            PH_ASHI:  r_d.phase = PH_FLOAT;
            PH_FLOAT: begin
                r_d.phase = PH_DSLO;
                load      = 1'b1;
            end
            PH_DSLO: if (ds_last) begin
                r_d.phase = PH_DSHI;
                if (r_q.rd) r_d.rdata = ad_i;
            end
            PH_DSHI:  r_d.phase = PH_DONE;
            PH_DONE:  r_d.phase = PH_IDLE;
            default:  r_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    xbus_drive #(.W(W)) u_drive (
        .phase (r_q.phase),
        .addr  (r_q.addr),
        .wdata (r_q.wdata),
        .rd    (r_q.rd),
        .ad_o  (ad_o),
        .ad_oe (ad_oe_o),
        .as_n  (as_n_o),
        .ds_n  (ds_n_o),
        .rw_n  (rw_n_o),
        .done  (done_o)
    );

    assign rdata_o = r_q.rdata;

    p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n_o && !ds_n_o));

    p_as_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n_o) |=> as_n_o);

    p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n_o) |-> (ad_oe_o && ad_o == $past(ad_o)));

    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n_o) && rw_n_o) |-> (!ad_oe_o && !$past(ad_oe_o)));

    p_rw_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n_o |-> $stable(rw_n_o));

    p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ds_n_o) && !rw_n_o) |-> (ad_oe_o && $stable(ad_o)));

    p_ds_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n_o) && !r_q.ext) |=> ds_n_o);

    p_ds_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ds_n_o) && r_q.ext) |=> !ds_n_o);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_no_strobe_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> as_n_o);

endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0, rd_i = 1'b0, ext_i = 1'b0;
    logic [W-1:0] addr_i = '0, wdata_i = '0, ad_i = '0;
    logic [W-1:0] rdata_o, ad_o;
    logic         done_o, ad_oe_o, as_n_o, ds_n_o, rw_n_o;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    logic [W-1:0] last_rd = '0;

    always #2 clk = ~clk;

    xbus_seq #(.W(W), .EXTRA(2)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rd_i(rd_i), .ext_i(ext_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o),
        .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .as_n_o(as_n_o),
        .ds_n_o(ds_n_o), .rw_n_o(rw_n_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check(tag, "as_n", as_n_o, 1);
        check(tag, "ds_n", ds_n_o, 1);
        check(tag, "rw_n", rw_n_o, 1);
        check(tag, "oe", ad_oe_o, 0);
        check(tag, "done", done_o, 0);
    endtask

    function automatic int ds_len(input logic ext);
        return ext ? 3 : 1;
    endfunction

    task automatic run_txn(input logic [W-1:0] a, input logic [W-1:0] wd,
                           input logic [W-1:0] rv, input logic rd,
                           input logic ext, input logic hold);
        int L;
        L = ds_len(ext);
        @(negedge clk);
        req_i = 1'b1; addr_i = a; wdata_i = wd; rd_i = rd; ext_i = ext; ad_i = ~rv;
        for (int k = 1; k <= L + 5; k++) begin
            @(negedge clk);
            if (k == 1) begin
                addr_i = ~a; wdata_i = ~wd; rd_i = ~rd; ext_i = ~ext;
                if (!hold) req_i = 1'b0;
            end
            if (k == 3) req_i = 1'b0;
            // R2 and R11: strobe phases
            check("R2", "as_n", as_n_o, (k == 1) ? 0 : 1);
            check("R7", "ds_n", ds_n_o, (k >= 4 && k <= 3 + L) ? 0 : 1);
            check("R5", "rw_n", rw_n_o, (k <= 4 + L) ? rd : 1'b1);
            if (k <= 2) begin
                check((k == 1) ? "R2" : "R3", "oe", ad_oe_o, 1);
                check((k == 1) ? "R2" : "R3", "addr", ad_o, a);
            end else if (k <= 4 + L) begin
                if (rd) check("R4", "oe", ad_oe_o, 0);
                else begin
                    check("R6", "oe", ad_oe_o, 1);
                    check("R6", "wdata", ad_o, wd);
                end
            end else begin
                check("R1", "oe", ad_oe_o, 0);
            end
            check("R9", "done", done_o, (k == L + 5) ? 1 : 0);
            if (k == L + 5) begin
                if (rd) last_rd = rv;
                check("R8", "rdata", rdata_o, last_rd);
            end
            ad_i = (k == 3 + L) ? rv : ~rv;
        end
        @(negedge clk);
        check_idle("R10");
        check("R8", "rdata held", rdata_o, last_rd);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
        check("R1", "rdata", rdata_o, 0);

        // directed corners
        run_txn(8'h5A, 8'h00, 8'hC3, 1'b1, 1'b0, 1'b0); // plain read
        run_txn(8'hA5, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b0); // plain write, R8 unchanged
        run_txn(8'hFF, 8'h00, 8'h81, 1'b1, 1'b1, 1'b1); // stretched read, req held (R10)
        run_txn(8'h00, 8'hE7, 8'h00, 1'b0, 1'b1, 1'b1); // stretched write, req held
        // back to back with no gap
        run_txn(8'h11, 8'h22, 8'h33, 1'b1, 1'b1, 1'b0);

        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] a, wd, rv;
            logic rd, ext, hold;
            a = W'($urandom); wd = W'($urandom); rv = W'($urandom);
            rd = 1'($urandom); ext = 1'($urandom); hold = 1'($urandom);
            run_txn(a, wd, rv, rd, ext, hold);
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                check_idle("R1");
            end
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule